// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Unit

This block sits in front of the ALU of a five-stage in-order pipeline. For each of the two ALU operands, it decides where the freshest copy of the source register lives. The choices are the register-file read data that travelled with the instruction into execute, the ALU result of the instruction one step ahead (held in the execute/memory pipeline register), or the final writeback value of the instruction two steps ahead (held in the memory/writeback pipeline register). It then steers that value onto the operand.

A hazard exists only when an older instruction is going to write the register file and its destination number equals a source number of the instruction in execute. The nearer producer always wins, because it carries the more recent value. Destination register 0 never forwards, since that register always reads as zero. An instruction three positions behind a producer needs no bypass. The register file is written early in a cycle and read later in the same cycle, so it already returns the new value. The whole unit is combinational: selects and operands settle in the same cycle as their inputs.

Top module: `operand_bypass`

## Requirements
- R1: With no qualifying match for an operand, its select (fwdA or fwdB) is 0 and the operand equals its register-file read data (exRsData or exRtData).
- R2: When memRegWrite is 1, memRd is non-zero and memRd equals exRs, fwdA is 2 and aluOpA equals memAluResult.
- R3: When memRegWrite is 1, memRd is non-zero and memRd equals exRt, fwdB is 2 and aluOpB equals memAluResult.
- R4: When wbRegWrite is 1, wbRd is non-zero and wbRd equals an operand's source register, and the R2/R3 condition for that operand does not hold, its select is 1 and the operand equals wbValue.
- R5: When both the memory-stage and writeback-stage producers match the same source register, the select is 2 and the memory-stage ALU result is used.
- R6: A destination register number of 0 never causes forwarding from either stage, even with its write enable at 1 and a matching source register 0.
- R7: A producer whose write enable is 0 never causes forwarding, whatever its destination number.
- R8: The two operands are decided independently, so in the same cycle one operand may take select 2 while the other takes select 1 or 0. The select value 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| exRs | input | 5 | First source register number of the instruction in execute |
| exRt | input | 5 | Second source register number of the instruction in execute |
| exRsData | input | 32 | Register-file read data for the first source |
| exRtData | input | 32 | Register-file read data for the second source |
| memRegWrite | input | 1 | Write enable of the instruction in the memory stage |
| memRd | input | 5 | Destination register of the instruction in the memory stage |
| memAluResult | input | 32 | ALU result held in the execute/memory register |
| wbRegWrite | input | 1 | Write enable of the instruction in writeback |
| wbRd | input | 5 | Destination register of the instruction in writeback |
| wbValue | input | 32 | Value being written back (after the load/ALU choice) |
| fwdA | output | 2 | Select of the first operand: 0 register, 1 writeback, 2 memory stage |
| fwdB | output | 2 | Select of the second operand, same encoding |
| aluOpA | output | 32 | First ALU operand |
| aluOpB | output | 32 | Second ALU operand |

## Verification
The bench draws register numbers from a narrow range, so matches, double matches and register-0 destinations occur often. It also aims directed cases at the priority tie, at register 0 and at cleared write enables. A design that put writeback ahead of the memory stage would hand a stale value to the ALU and show select 1 where 2 is expected. One that ignored register 0 would forward a non-zero value for a hard-wired zero. One that ignored the write enable would bypass data from stores or branches. Mixed cycles, where the two operands need different sources, catch a design that shares one decision between both operands.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int REG_AW = 5;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    SEL_REG = 2'd0,
    SEL_WB  = 2'd1,
    SEL_MEM = 2'd2
  } fwdSel_e;

  // strobes from control to datapath
  typedef struct packed {
    fwdSel_e selA;
    fwdSel_e selB;
  } fwdCtrl_t;
endpackage

// File: rtl/fwd_control.sv
module fwd_control
  import fwd_pkg::*;
#(
  parameter int  REG_W    = REG_AW,
  parameter bit  ZERO_REG = 1'b1
) (
  input  logic [REG_W-1:0] srcA,
  input  logic [REG_W-1:0] srcB,
  input  logic             memWe,
  input  logic [REG_W-1:0] memDst,
  input  logic             wbWe,
  input  logic [REG_W-1:0] wbDst,
  output fwdCtrl_t         ctrl
);
  localparam int NSRC = 2;

  logic             memLive;
  logic             wbLive;
  logic [REG_W-1:0] src [NSRC];
  fwdSel_e          sel [NSRC];

  // a producer qualifies only if it writes and, when register 0 is wired, not to r0
  generate
    if (ZERO_REG) begin : g_zero
      assign memLive = memWe && (memDst != '0);
      assign wbLive  = wbWe  && (wbDst  != '0);
    end else begin : g_nozero
      assign memLive = memWe;
      assign wbLive  = wbWe;
    end
  endgenerate

  assign src[0] = srcA;
  assign src[1] = srcB;

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      always_comb begin
        if (memLive && (memDst == src[i]))
          sel[i] = SEL_MEM;
        else if (wbLive && (wbDst == src[i]))
          sel[i] = SEL_WB;
        else
          sel[i] = SEL_REG;
      end
    end
  endgenerate

  assign ctrl.selA = sel[0];
  assign ctrl.selB = sel[1];
endmodule

// File: rtl/fwd_datapath.sv
module fwd_datapath
  import fwd_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  fwdCtrl_t      ctrl,
  input  logic [DW-1:0] regA,
  input  logic [DW-1:0] regB,
  input  logic [DW-1:0] memVal,
  input  logic [DW-1:0] wbVal,
  output logic [DW-1:0] opA,
  output logic [DW-1:0] opB
);
  localparam int NOP = 2;

  fwdSel_e       sel [NOP];
  logic [DW-1:0] reg_ [NOP];
  logic [DW-1:0] res [NOP];

  assign sel[0]  = ctrl.selA;
  assign sel[1]  = ctrl.selB;
  assign reg_[0] = regA;
  assign reg_[1] = regB;

  generate
    for (genvar i = 0; i < NOP; i++) begin : g_mux
      always_comb begin
        case (sel[i])
          SEL_MEM: res[i] = memVal;
          SEL_WB:  res[i] = wbVal;
          default: res[i] = reg_[i];
        endcase
      end
    end
  endgenerate

  assign opA = res[0];
  assign opB = res[1];
endmodule

// File: rtl/operand_bypass.sv
module operand_bypass
  import fwd_pkg::*;
#(
  parameter int REG_W    = REG_AW,
  parameter int DW       = DATA_W,
  parameter bit ZERO_REG = 1'b1
) (
  input  logic [REG_W-1:0] exRs,
  input  logic [REG_W-1:0] exRt,
  input  logic [DW-1:0]    exRsData,
  input  logic [DW-1:0]    exRtData,
  input  logic             memRegWrite,
  input  logic [REG_W-1:0] memRd,
  input  logic [DW-1:0]    memAluResult,
  input  logic             wbRegWrite,
  input  logic [REG_W-1:0] wbRd,
  input  logic [DW-1:0]    wbValue,
  output logic [1:0]       fwdA,
  output logic [1:0]       fwdB,
  output logic [DW-1:0]    aluOpA,
  output logic [DW-1:0]    aluOpB
);
  fwdCtrl_t ctrl;

  fwd_control #(.REG_W(REG_W), .ZERO_REG(ZERO_REG)) u_ctrl (
    .srcA(exRs), .srcB(exRt),
    .memWe(memRegWrite), .memDst(memRd),
    .wbWe(wbRegWrite), .wbDst(wbRd),
    .ctrl(ctrl)
  );

  fwd_datapath #(.DW(DW)) u_dp (
    .ctrl(ctrl),
    .regA(exRsData), .regB(exRtData),
    .memVal(memAluResult), .wbVal(wbValue),
    .opA(aluOpA), .opB(aluOpB)
  );

  assign fwdA = ctrl.selA;
  assign fwdB = ctrl.selB;
endmodule

// File: rtl/fwd_checker.sv
module fwd_checker #(
  parameter int REG_W = 5,
  parameter int DW    = 32
) (
  input logic [REG_W-1:0] exRs,
  input logic [REG_W-1:0] exRt,
  input logic [DW-1:0]    exRsData,
  input logic [DW-1:0]    exRtData,
  input logic             memRegWrite,
  input logic [REG_W-1:0] memRd,
  input logic [DW-1:0]    memAluResult,
  input logic             wbRegWrite,
  input logic [REG_W-1:0] wbRd,
  input logic [DW-1:0]    wbValue,
  input logic [1:0]       fwdA,
  input logic [1:0]       fwdB,
  input logic [DW-1:0]    aluOpA,
  input logic [DW-1:0]    aluOpB
);
  logic known;
  assign known = !$isunknown({exRs, exRt, memRegWrite, memRd, wbRegWrite, wbRd});

  always_comb begin
    if (known) begin
      // R2 / R5: live memory-stage match on first source takes select 2
      a_r2_mem_to_a: assert (!(memRegWrite && memRd != '0 && memRd == exRs) || fwdA == 2'd2);
      // R3: same for second source
      a_r3_mem_to_b: assert (!(memRegWrite && memRd != '0 && memRd == exRt) || fwdB == 2'd2);
      // R4: select 1 only with a live writeback match
      a_r4_wb_needs_match: assert (fwdA != 2'd1 || (wbRegWrite && wbRd != '0 && wbRd == exRs));
      // R6 / R7: no forwarding from a disabled or r0 producer onto a r0 source
      a_r6_zero_src: assert (exRs != '0 || fwdA == 2'd0);
      // R8: select 3 never appears
      a_r8_no_sel3: assert (fwdA != 2'd3 && fwdB != 2'd3);
      // R1: operand follows select
      a_r1_opa_follows: assert (fwdA != 2'd0 || aluOpA == exRsData);
      a_r1_opb_follows: assert (fwdB != 2'd2 || aluOpB == memAluResult);
      a_r4_opb_wb: assert (fwdB != 2'd1 || aluOpB == wbValue);
    end
  end
endmodule

bind operand_bypass fwd_checker #(.REG_W(REG_W), .DW(DW)) u_chk (
  .exRs(exRs), .exRt(exRt), .exRsData(exRsData), .exRtData(exRtData),
  .memRegWrite(memRegWrite), .memRd(memRd), .memAluResult(memAluResult),
  .wbRegWrite(wbRegWrite), .wbRd(wbRd), .wbValue(wbValue),
  .fwdA(fwdA), .fwdB(fwdB), .aluOpA(aluOpA), .aluOpB(aluOpB)
);

// File: tb/sim_operand_bypass.sv
module sim_operand_bypass;
  localparam int CLK_PERIOD = 10;
  localparam int NRAND      = 2000;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [4:0]  exRs, exRt, memRd, wbRd;
  logic [31:0] exRsData, exRtData, memAluResult, wbValue;
  logic        memRegWrite, wbRegWrite;
  logic [1:0]  fwdA, fwdB;
  logic [31:0] aluOpA, aluOpB;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  operand_bypass u0 (.*);

  function automatic logic [1:0] expSel(logic mw, logic [4:0] md, logic ww, logic [4:0] wd,
                                        logic [4:0] s);
    if (mw && md != 5'd0 && md == s) return 2'd2;
    if (ww && wd != 5'd0 && wd == s) return 2'd1;
    return 2'd0;
  endfunction

  function automatic logic [31:0] expOp(logic [1:0] sel, logic [31:0] r);
    case (sel)
      2'd2:    return memAluResult;
      2'd1:    return wbValue;
      default: return r;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [4:0] rs, logic [4:0] rt, logic mw, logic [4:0] md,
                       logic ww, logic [4:0] wd, string req);
    logic [1:0] ea, eb;
    @(posedge clk);
    exRs = rs; exRt = rt; memRegWrite = mw; memRd = md; wbRegWrite = ww; wbRd = wd;
    exRsData = $urandom; exRtData = $urandom; memAluResult = $urandom; wbValue = $urandom;
    @(negedge clk);
    ea = expSel(mw, md, ww, wd, rs);
    eb = expSel(mw, md, ww, wd, rt);
    check({req, " selA"}, {30'd0, fwdA}, {30'd0, ea});
    check({req, " selB"}, {30'd0, fwdB}, {30'd0, eb});
    check({req, " opA"}, aluOpA, expOp(ea, exRsData));
    check({req, " opB"}, aluOpB, expOp(eb, exRtData));
  endtask

  initial begin
    int seed = 1234;
    void'($urandom(seed));
    exRs = 0; exRt = 0; memRd = 0; wbRd = 0; memRegWrite = 0; wbRegWrite = 0;
    exRsData = 32'h11; exRtData = 32'h22; memAluResult = 32'h33; wbValue = 32'h44;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset-state: nothing live, register data passes
    check("R1 reset selA", {30'd0, fwdA}, 32'd0);
    check("R1 reset opB", aluOpB, 32'h22);

    apply(5'd3, 5'd4, 1, 5'd7, 1, 5'd8, "R1 nomatch");
    apply(5'd7, 5'd4, 1, 5'd7, 0, 5'd0, "R2 mem to A");
    apply(5'd1, 5'd9, 1, 5'd9, 0, 5'd9, "R3 mem to B");
    apply(5'd12, 5'd12, 0, 5'd12, 1, 5'd12, "R4 wb both");
    apply(5'd5, 5'd5, 1, 5'd5, 1, 5'd5, "R5 priority");
    apply(5'd0, 5'd0, 1, 5'd0, 1, 5'd0, "R6 r0 dest");
    apply(5'd6, 5'd6, 0, 5'd6, 0, 5'd6, "R7 no write");
    apply(5'd10, 5'd11, 1, 5'd10, 1, 5'd11, "R8 A mem B wb");
    apply(5'd31, 5'd2, 0, 5'd31, 1, 5'd31, "R8 A wb B reg");

    for (int i = 0; i < NRAND; i++) begin
      apply(5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)), 1'($urandom),
            5'($urandom_range(0, 3)), 1'($urandom), 5'($urandom_range(0, 3)), "R1-mix random");
    end
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule